// File: doc/BRIEF.md
# Speculative L0 Filter Cache

This block is a tiny, fully associative level-0 data cache placed between an out-of-order core and its L1 data cache. Every line fetched on behalf of a load that has not yet retired is kept here and only here. The line is not allocated in L1, and no replacement or prefetch activity is triggered there. A line is copied outward, through a dedicated promotion queue, only when a load that used it is reported as committed. Loads that are squashed leave their lines resident but no longer owned. A protection-domain change clears the whole array in one cycle, so the next domain cannot observe anything the previous one touched speculatively.

The core presents one load at a time with a line address and its reorder-buffer tag. A hit answers one cycle later. A miss stalls the load port and issues a non-allocating line read toward L1. The returned line is answered to the core and installed in the way that replacement selects. Commit and squash notices arrive on a separate port, which is held off while the promotion queue is full. The filter cache and L1 are neither inclusive nor exclusive of each other, and nothing here invalidates L1.

Top module: `spec_filter_cache`

## Requirements
- R1: After reset every line is invalid, `ld_ready` and `cm_ready` are 1, and `rsp_valid`, `l1_req_valid` and `pr_valid` are 0.
- R2: A load to a resident line raises `rsp_valid` with that line's data in the cycle after it is accepted, and no L1 read is issued.
- R3: A load to an absent line drops `ld_ready` and raises `l1_req_valid` in the cycle after acceptance. `l1_req_addr` holds the line address until `l1_rsp_valid`. The cycle after the response, the core receives the line and `ld_ready` returns. The fill produces no promotion.
- R4: A commit notice (`cm_squash`=0) whose tag owns a speculative line pushes that line's address and data to the promotion port once and marks the line committed.
- R5: A load that hits a committed line takes no ownership of it, and a later commit of that load's tag promotes nothing.
- R6: A squash notice (`cm_squash`=1) whose tag owns a line leaves the line valid, so a later load still hits, but releases ownership, so a commit of that tag promotes nothing.
- R7: A load that hits a speculative line becomes its owner. A commit of the previous owner's tag then promotes nothing.
- R8: `dom_flush` invalidates every line at the next clock edge, and all subsequent loads miss.
- R9: When `dom_flush` and `l1_rsp_valid` coincide, the core still receives the data but the line is not installed, so a repeat load misses.
- R10: A fill takes the lowest-numbered invalid way. With every way valid, it takes the way chosen by a binary-tree pseudo-LRU that every hit and fill updates. After flushing, filling lines L0..L7 in order and hitting L0, a ninth line evicts L4.
- R11: Promotions leave in commit order. With 4 promotions pending, `cm_ready` is 0 and a held notice is not taken. It is taken once space frees, and the head entry stays stable while `pr_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load port can accept (low while a miss is outstanding) |
| ld_line | input | LA_W | Line address of the load |
| ld_tag | input | TAG_W | Reorder-buffer tag of the load |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | LINE_BYTES*8 | Line returned to the core |
| cm_valid | input | 1 | Commit or squash notice valid |
| cm_ready | output | 1 | Notice port can accept |
| cm_squash | input | 1 | 1 = squash, 0 = commit |
| cm_tag | input | TAG_W | Tag of the committed or squashed load |
| dom_flush | input | 1 | Protection-domain switch: invalidate all lines |
| l1_req_valid | output | 1 | Non-allocating line read toward L1 |
| l1_req_addr | output | LA_W | Line address of the read |
| l1_rsp_valid | input | 1 | Read data valid |
| l1_rsp_data | input | LINE_BYTES*8 | Line returned by L1 |
| pr_valid | output | 1 | Promotion entry valid |
| pr_ready | input | 1 | L1 accepts the promotion |
| pr_addr | output | LA_W | Line address being promoted |
| pr_data | output | LINE_BYTES*8 | Line data being promoted |

## Verification
A hit answers on the first edge after acceptance. A miss request is visible after that same edge, and the fill answer follows one edge after `l1_rsp_valid`. A promotion is visible one edge after the notice is taken. A flush is in force one edge after it is sampled. The bench drives every input on the falling edge and samples exactly one rising edge later, on the next falling edge. For misses it waits an extra cycle before answering, so it can see the request held stable. The expected data of each line is a pattern computed from its address, and the expected victim way comes from working the tree by hand.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  // Miss handling state of the load port
  typedef enum logic {
    SFC_IDLE = 1'b0,
    SFC_WAIT = 1'b1
  } sfc_state_e;
endpackage

// File: rtl/sfc_plru.sv
module sfc_plru #(
  parameter int WAYS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [$clog2(WAYS)-1:0]  touch_way,
  input  logic [WAYS-1:0]          valid_vec,
  output logic [$clog2(WAYS)-1:0]  victim
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-2:0]  tree_q;
  logic [WAY_W-1:0] free_way;

  // walk the tree: bit 0 sends the search left, 1 sends it right
  function automatic logic [WAY_W-1:0] tree_pick(input logic [WAYS-2:0] t);
    int node;
    logic [WAY_W-1:0] w;
    node = 0;
    w    = '0;
    for (int l = 0; l < WAY_W; l++) begin
      w    = (w << 1) | WAY_W'(t[node]);
      node = 2 * node + 1 + int'(t[node]);
    end
    return w;
  endfunction

  // mark a way as recent: every node on its path points away from it
  function automatic logic [WAYS-2:0] tree_mark(input logic [WAYS-2:0] t,
                                                input logic [WAY_W-1:0] way);
    int node;
    logic d;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      d       = way[WAY_W-1-l];
      t[node] = ~d;
      node    = 2 * node + 1 + int'(d);
    end
    return t;
  endfunction

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) free_way = WAY_W'(w);
    end
  end

  assign victim = (&valid_vec) ? tree_pick(tree_q) : free_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tree_q <= '0;
    else if (touch_en) tree_q <= tree_mark(tree_q, touch_way);
  end
endmodule

// File: rtl/sfc_promo_fifo.sv
module sfc_promo_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt_q == CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign out_data  = mem[rd_q];
  assign do_push   = push & ~full;
  assign do_pop    = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/spec_filter_cache.sv
module spec_filter_cache
  import sfc_pkg::*;
#(
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 64,
  parameter int LA_W       = 26,
  parameter int TAG_W      = 6,
  parameter int PQ_DEPTH   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  output logic                      ld_ready,
  input  logic [LA_W-1:0]           ld_line,
  input  logic [TAG_W-1:0]          ld_tag,
  output logic                      rsp_valid,
  output logic [LINE_BYTES*8-1:0]   rsp_data,
  input  logic                      cm_valid,
  output logic                      cm_ready,
  input  logic                      cm_squash,
  input  logic [TAG_W-1:0]          cm_tag,
  input  logic                      dom_flush,
  output logic                      l1_req_valid,
  output logic [LA_W-1:0]           l1_req_addr,
  input  logic                      l1_rsp_valid,
  input  logic [LINE_BYTES*8-1:0]   l1_rsp_data,
  output logic                      pr_valid,
  input  logic                      pr_ready,
  output logic [LA_W-1:0]           pr_addr,
  output logic [LINE_BYTES*8-1:0]   pr_data
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int PQ_W   = LA_W + LINE_W;

  sfc_state_e        st_q;
  logic [LA_W-1:0]   pend_la_q;
  logic [TAG_W-1:0]  pend_tag_q;

  // per-way state and payload
  logic [WAYS-1:0]   v_q, spec_q, own_q;
  logic [TAG_W-1:0]  tag_q  [WAYS];
  logic [LA_W-1:0]   la_q   [WAYS];
  logic [LINE_W-1:0] data_q [WAYS];

  // named internal events (observed by the bound checker)
  logic [WAYS-1:0]   hit_vec, cm_match;
  logic [WAY_W-1:0]  hit_way, cm_way, victim, touch_way;
  logic              ld_fire, hit_evt, miss_evt, cm_fire;
  logic              promo_push, squash_evt, fill_evt, fill_write;
  logic              pq_full, touch_en;
  logic [PQ_W-1:0]   pq_out;

  function automatic logic [WAY_W-1:0] lowest_set(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w]  = v_q[w] && (la_q[w] == ld_line);
    assign cm_match[w] = v_q[w] && spec_q[w] && own_q[w] && (tag_q[w] == cm_tag);
  end

  assign hit_way    = lowest_set(hit_vec);
  assign cm_way     = lowest_set(cm_match);
  assign ld_ready   = (st_q == SFC_IDLE);
  assign ld_fire    = ld_valid & ld_ready;
  assign hit_evt    = ld_fire & (|hit_vec);
  assign miss_evt   = ld_fire & ~(|hit_vec);
  assign cm_ready   = ~pq_full;
  assign cm_fire    = cm_valid & cm_ready;
  assign promo_push = cm_fire & ~cm_squash & (|cm_match);
  assign squash_evt = cm_fire & cm_squash;
  assign fill_evt   = (st_q == SFC_WAIT) & l1_rsp_valid;
  assign fill_write = fill_evt & ~dom_flush;
  assign touch_en   = hit_evt | fill_write;
  assign touch_way  = hit_evt ? hit_way : victim;

  assign l1_req_valid = (st_q == SFC_WAIT);
  assign l1_req_addr  = pend_la_q;

  sfc_plru #(.WAYS(WAYS)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_way (touch_way),
    .valid_vec (v_q),
    .victim    (victim)
  );

  sfc_promo_fifo #(.DEPTH(PQ_DEPTH), .W(PQ_W)) u_pq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (promo_push),
    .push_data ({la_q[cm_way], data_q[cm_way]}),
    .full      (pq_full),
    .out_valid (pr_valid),
    .out_ready (pr_ready),
    .out_data  (pq_out)
  );

  assign pr_addr = pq_out[PQ_W-1:LINE_W];
  assign pr_data = pq_out[LINE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SFC_IDLE;
      pend_la_q  <= '0;
      pend_tag_q <= '0;
      rsp_valid  <= 1'b0;
    end else begin
      rsp_valid <= hit_evt | fill_evt;
      if (miss_evt) begin
        st_q       <= SFC_WAIT;
        pend_la_q  <= ld_line;
        pend_tag_q <= ld_tag;
      end else if (fill_evt) begin
        st_q <= SFC_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit_evt)       rsp_data <= data_q[hit_way];
    else if (fill_evt) rsp_data <= l1_rsp_data;
  end

  // state bits: commit, squash, hit takeover, fill, then flush (last wins)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= '0;
      spec_q <= '0;
      own_q  <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (promo_push && cm_way == WAY_W'(w)) spec_q[w] <= 1'b0;
        if (squash_evt && cm_match[w])        own_q[w]  <= 1'b0;
        if (hit_evt && hit_way == WAY_W'(w) && spec_q[w]) own_q[w] <= 1'b1;
        if (fill_write && victim == WAY_W'(w)) begin
          v_q[w]    <= 1'b1;
          spec_q[w] <= 1'b1;
          own_q[w]  <= 1'b1;
        end
        if (dom_flush) v_q[w] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (hit_evt && hit_way == WAY_W'(w) && spec_q[w]) tag_q[w] <= ld_tag;
      if (fill_write && victim == WAY_W'(w)) begin
        tag_q[w]  <= pend_tag_q;
        la_q[w]   <= pend_la_q;
        data_q[w] <= l1_rsp_data;
      end
    end
  end
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int LA_W = 26,
  parameter int WAYS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_ready,
  input logic            l1_req_valid,
  input logic [LA_W-1:0] l1_req_addr,
  input logic            l1_rsp_valid,
  input logic            rsp_valid,
  input logic            pr_valid,
  input logic            pr_ready,
  input logic [LA_W-1:0] pr_addr,
  input logic            cm_ready,
  input logic            dom_flush,
  input logic            hit_evt,
  input logic            fill_evt,
  input logic            promo_push,
  input logic [WAYS-1:0] v_q
);
  // R2
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> rsp_valid && !l1_req_valid);

  // R3
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l1_req_valid && !l1_rsp_valid |=> l1_req_valid && $stable(l1_req_addr));

  // R3
  fill_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt |=> rsp_valid && ld_ready);

  // R4
  promo_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    promo_push |=> pr_valid);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_flush |=> (v_q == '0));

  // R11
  promo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pr_valid && !pr_ready |=> pr_valid && $stable(pr_addr));

  // R11
  block_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_ready |-> pr_valid);
endmodule

bind spec_filter_cache sfc_chk #(.LA_W(LA_W), .WAYS(WAYS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_ready     (ld_ready),
  .l1_req_valid (l1_req_valid),
  .l1_req_addr  (l1_req_addr),
  .l1_rsp_valid (l1_rsp_valid),
  .rsp_valid    (rsp_valid),
  .pr_valid     (pr_valid),
  .pr_ready     (pr_ready),
  .pr_addr      (pr_addr),
  .cm_ready     (cm_ready),
  .dom_flush    (dom_flush),
  .hit_evt      (hit_evt),
  .fill_evt     (fill_evt),
  .promo_push   (promo_push),
  .v_q          (v_q)
);

// File: tb/sim_spec_filter_cache.sv
module sim_spec_filter_cache;
  localparam int CLK_PERIOD = 10;
  localparam int LA_W   = 26;
  localparam int TAG_W  = 6;
  localparam int LINE_W = 512;
  localparam int NV     = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_valid = 1'b0;
  logic              ld_ready;
  logic [LA_W-1:0]   ld_line = '0;
  logic [TAG_W-1:0]  ld_tag = '0;
  logic              rsp_valid;
  logic [LINE_W-1:0] rsp_data;
  logic              cm_valid = 1'b0;
  logic              cm_ready;
  logic              cm_squash = 1'b0;
  logic [TAG_W-1:0]  cm_tag = '0;
  logic              dom_flush = 1'b0;
  logic              l1_req_valid;
  logic [LA_W-1:0]   l1_req_addr;
  logic              l1_rsp_valid = 1'b0;
  logic [LINE_W-1:0] l1_rsp_data = '0;
  logic              pr_valid;
  logic              pr_ready = 1'b1;
  logic [LA_W-1:0]   pr_addr;
  logic [LINE_W-1:0] pr_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spec_filter_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_line(ld_line), .ld_tag(ld_tag),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_squash(cm_squash), .cm_tag(cm_tag),
    .dom_flush(dom_flush),
    .l1_req_valid(l1_req_valid), .l1_req_addr(l1_req_addr),
    .l1_rsp_valid(l1_rsp_valid), .l1_rsp_data(l1_rsp_data),
    .pr_valid(pr_valid), .pr_ready(pr_ready), .pr_addr(pr_addr), .pr_data(pr_data)
  );

  // op: 0 load, 1 commit, 2 squash; exp: load -> hit, notice -> promotion
  typedef struct packed {
    logic [1:0]      op;
    logic [LA_W-1:0] la;
    logic [TAG_W-1:0] tag;
    logic            exp;
    logic [3:0]      rn;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd0, 26'h101, 6'd1, 1'b0, 4'd3},  // R3 first touch misses
    '{2'd0, 26'h101, 6'd2, 1'b1, 4'd2},  // R2 hit; R7 tag 2 takes ownership
    '{2'd1, 26'h101, 6'd1, 1'b0, 4'd7},  // R7 former owner promotes nothing
    '{2'd1, 26'h101, 6'd2, 1'b1, 4'd4},  // R4 owner commit promotes
    '{2'd0, 26'h101, 6'd3, 1'b1, 4'd5},  // R5 hit on committed line
    '{2'd1, 26'h101, 6'd3, 1'b0, 4'd5},  // R5 no second promotion
    '{2'd0, 26'h102, 6'd4, 1'b0, 4'd3},  // R3 second line misses
    '{2'd2, 26'h102, 6'd4, 1'b0, 4'd6},  // R6 squash
    '{2'd1, 26'h102, 6'd4, 1'b0, 4'd6},  // R6 squashed tag promotes nothing
    '{2'd0, 26'h102, 6'd5, 1'b1, 4'd6},  // R6 line still resident
    '{2'd1, 26'h102, 6'd5, 1'b1, 4'd4}   // R4 new owner promotes
  };

  function automatic logic [LINE_W-1:0] pat(input logic [LA_W-1:0] la);
    logic [LINE_W-1:0] r;
    for (int k = 0; k < LINE_W / 32; k++) r[k*32 +: 32] = {la, 6'(k)} ^ 32'h5A5A_0000;
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [LA_W-1:0] la, input logic [TAG_W-1:0] tag,
                         input bit exp_hit, input bit with_flush, input string rq);
    logic [LINE_W-1:0] want;
    want = pat(la);
    @(negedge clk);
    ld_valid = 1'b1; ld_line = la; ld_tag = tag;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    if (exp_hit)
      chk(rsp_valid && !l1_req_valid, rq, "hit reply", {62'd0, l1_req_valid, rsp_valid}, 64'd1);
    else
      chk(l1_req_valid && !rsp_valid && !ld_ready && l1_req_addr == la, rq, "miss request",
          64'(l1_req_addr), 64'(la));
    if (rsp_valid)
      chk(rsp_data == want, rq, "hit data", rsp_data[63:0], want[63:0]);
    if (l1_req_valid) begin
      @(posedge clk);
      @(negedge clk);
      chk(l1_req_valid && l1_req_addr == la, rq, "request held", 64'(l1_req_addr), 64'(la));
      l1_rsp_valid = 1'b1; l1_rsp_data = want; dom_flush = with_flush;
      @(posedge clk);
      @(negedge clk);
      l1_rsp_valid = 1'b0; dom_flush = 1'b0;
      chk(rsp_valid && ld_ready && rsp_data == want, rq, "fill data", rsp_data[63:0], want[63:0]);
      if (pr_ready) chk(!pr_valid, rq, "fill makes no promotion", 64'(pr_valid), 64'd0);
    end
  endtask

  task automatic do_cm(input logic [TAG_W-1:0] tag, input bit squash, input bit exp_pr,
                       input logic [LA_W-1:0] la, input string rq);
    logic [LINE_W-1:0] want;
    want = pat(la);
    @(negedge clk);
    cm_valid = 1'b1; cm_tag = tag; cm_squash = squash;
    @(posedge clk);
    @(negedge clk);
    cm_valid = 1'b0; cm_squash = 1'b0;
    chk(pr_valid == exp_pr, rq, "promotion present", 64'(pr_valid), 64'(exp_pr));
    if (exp_pr && pr_valid) begin
      chk(pr_addr == la, rq, "promotion addr", 64'(pr_addr), 64'(la));
      chk(pr_data == want, rq, "promotion data", pr_data[63:0], want[63:0]);
    end
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    dom_flush = 1'b1;
    @(posedge clk);
    @(negedge clk);
    dom_flush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ld_ready && cm_ready && !rsp_valid && !l1_req_valid && !pr_valid, "R1", "reset outputs",
        {59'd0, ld_ready, cm_ready, rsp_valid, l1_req_valid, pr_valid}, 64'h18);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].rn);
      if (VEC[i].op == 2'd0) do_load(VEC[i].la, VEC[i].tag, VEC[i].exp, 1'b0, rq);
      else do_cm(VEC[i].tag, VEC[i].op == 2'd2, VEC[i].exp, VEC[i].la, rq);
    end

    // R8 domain flush empties the array
    pulse_flush();
    do_load(26'h101, 6'd6, 1'b0, 1'b0, "R8");
    do_load(26'h102, 6'd7, 1'b0, 1'b0, "R8");

    // R9 flush racing a fill: data delivered, line dropped
    do_load(26'h300, 6'd8, 1'b0, 1'b1, "R9");
    do_load(26'h300, 6'd9, 1'b0, 1'b0, "R9");

    // R10 invalid ways first, then tree pseudo-LRU: L4 is the victim
    pulse_flush();
    for (int k = 0; k < 8; k++) do_load(26'h100 + 26'(k), 6'(30 + k), 1'b0, 1'b0, "R10");
    do_load(26'h100, 6'd40, 1'b1, 1'b0, "R10");
    do_load(26'h108, 6'd41, 1'b0, 1'b0, "R10");
    do_load(26'h104, 6'd42, 1'b0, 1'b0, "R10");

    // R11 promotion queue full blocks notices; order preserved
    pulse_flush();
    for (int k = 0; k < 5; k++) do_load(26'h200 + 26'(k), 6'(20 + k), 1'b0, 1'b0, "R11");
    pr_ready = 1'b0;
    for (int k = 0; k < 4; k++) do_cm(6'(20 + k), 1'b0, 1'b1, 26'h200, "R11");
    @(negedge clk);
    cm_valid = 1'b1; cm_tag = 6'd24; cm_squash = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(!cm_ready, "R11", "notice blocked", 64'(cm_ready), 64'd0);
      chk(pr_valid && pr_addr == 26'h200, "R11", "head stable", 64'(pr_addr), 64'h200);
      @(posedge clk);
      @(negedge clk);
    end
    cm_valid = 1'b0;
    pr_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(pr_valid && pr_addr == 26'h200 + 26'(k), "R11", "drain order",
          64'(pr_addr), 64'(26'h200 + 26'(k)));
      @(posedge clk);
      @(negedge clk);
    end
    chk(!pr_valid, "R11", "blocked notice not taken", 64'(pr_valid), 64'd0);
    do_cm(6'd24, 1'b0, 1'b1, 26'h204, "R11");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule